// File: doc/BRIEF.md
# Configurable Sinc Decimation Filter Channel

This block is one channel of a decimating filter for a single-bit sigma-delta stream. Each accepted input bit counts as +1 or -1. The bit feeds a chain of three integrators that run at the bit rate. Once every OSR accepted bits, a chain of three combs runs at the decimated rate and produces one filtered sample. The filter shape can be changed at run time. It is first, second or third order, plus a fast second-order variant whose second comb spans two decimated samples. Stages that the chosen shape does not need are skipped.

A channel can be disabled on its own. A shared sync strobe restarts several channels together. The strobe may come from a master enable edge or from a PWM-derived pulse. On restart the channel clears all filter state and suppresses its outputs until the filter window holds only bits taken after the restart. The result is given either at full precision, sign-extended to 32 bits, or as a 16-bit value that is shifted, saturated and then sign-extended.

Top module: `sinc_decim_chan`

## Requirements
- R1: `ftype` selects the impulse response (0: one box of length OSR, 1: two boxes of length OSR convolved, 2: a box of length OSR convolved with a box of length 2*OSR, 3: three boxes of length OSR convolved). An input bit of 1 counts as +1 and a bit of 0 as -1. Every sample equals the response applied to the most recent input bits, where bits taken before the last restart count as 0.
- R2: `osr_m1` holds OSR-1 (0..255, so OSR is 1..256). `data_rdy` pulses for one cycle in the cycle after every OSR-th accepted bit. An accepted bit is one with `bit_valid`=1, `en`=1 and `sync`=0.
- R3: After a restart, the first 0, 1, 2 and 2 decimation points are suppressed for `ftype` 0, 1, 2 and 3. No `data_rdy` pulse is given for them.
- R4: `sync`=1 clears the integrators, the combs and the bit counter, and starts a restart. A bit presented in the same cycle is discarded.
- R5: While `en`=0, input bits are ignored and `data_rdy` stays 0. The channel is held cleared, so enabling it again behaves like a restart.
- R6: With `wide`=1, `data_out` is the full-precision sample sign-extended to 32 bits. It is exact up to +/-OSR^3 with OSR=256.
- R7: With `wide`=0, the sample is shifted right arithmetically by `shift` (0..31). It is then saturated to the range -32768..32767 and sign-extended to 32 bits.
- R8: After reset, `data_out`=0 and `data_rdy`=0. `data_out` changes only in a cycle in which `data_rdy`=1 and holds its value otherwise, including while the channel is disabled.
- R9: Cycles with `bit_valid`=0 leave the filter state unchanged and do not advance decimation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable; 0 holds the channel cleared |
| sync | input | 1 | Restart strobe shared by a group of channels |
| bit_valid | input | 1 | Strobe marking a new modulator bit |
| bit_in | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| ftype | input | 2 | Filter shape: 0 first order, 1 second order, 2 fast second order, 3 third order |
| osr_m1 | input | 8 | Oversampling ratio minus one |
| wide | input | 1 | 1: 32-bit full result; 0: 16-bit scaled result |
| shift | input | 5 | Right shift applied in 16-bit mode |
| data_out | output | 32 | Filtered sample |
| data_rdy | output | 1 | One-cycle pulse when `data_out` is updated |

## Verification
Every filter shape is run at ratios 1, 2, 3, 4, 7 and 8, each with four inputs:
- Constant ones and constant zeros give the gain and sign of each shape.
- Alternating bits bring out the differences in kernel length and comb delay that set the fast variant apart from the plain second order.
- A pseudo-random stream with idle gaps shows that only valid bits count.

The full-scale third-order case at ratio 256 checks that the datapath width holds the largest value. The 16-bit tests cover saturation at both limits and the right shift. A restart in mid-stream and a disable and re-enable show that outputs are suppressed until fill and that old bits are dropped.

// File: rtl/sinc_pkg.sv
// Shared types for the sinc decimation channel.
package sinc_pkg;

    typedef enum logic [1:0] {
        FT_SINC1 = 2'd0,
        FT_SINC2 = 2'd1,
        FT_FAST  = 2'd2,
        FT_SINC3 = 2'd3
    } ftype_e;

endpackage

// File: rtl/sinc_integ.sv
// Integrator chain. Three integrators run at the bit rate. Each stage adds its
// input to its accumulator, and stage 0's input is the bit mapped to +1/-1.
// The updated sums are also given out combinationally, so the combs see the
// current bit in the same cycle. Assumes that modulo-2^W wrap is acceptable:
// the comb differences remove it.
module sinc_integ #(
    parameter int ACC_W  = 26,
    parameter int STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic                    bit_in,
    output logic [STAGES-1:0][ACC_W-1:0] acc_nxt
);

    logic [STAGES-1:0][ACC_W-1:0] acc_q;
    logic [ACC_W-1:0]             x_val;

    // Map the modulator bit to +1 or -1
    assign x_val = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign acc_nxt[k] = acc_q[k] + x_val;
        end else begin : g_rest
            assign acc_nxt[k] = acc_q[k] + acc_nxt[k-1];
        end

        // Update this stage on an accepted bit, clear on restart
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                acc_q[k] <= '0;
            end else if (step) begin
                acc_q[k] <= acc_nxt[k];
            end
        end
    end

    // R9: idle cycles leave the integrator state unchanged
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/sinc_decim_ctrl.sv
// Decimation control. Counts accepted bits modulo OSR, marks each decimation
// point, and tracks how many points have passed since a restart, so that
// outputs are suppressed until the filter window is full. Assumes osr_m1 and
// ftype are stable between restarts.
module sinc_decim_ctrl
    import sinc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] osr_m1,
    input  ftype_e           ftype,
    output logic             evt,
    output logic             emit
);

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       fills_q;
    logic [1:0]       need;

    // Number of decimation points to suppress after a restart
    always_comb begin
        unique case (ftype)
            FT_SINC1: need = 2'd0;
            FT_SINC2: need = 2'd1;
            default:  need = 2'd2;
        endcase
    end

    assign evt  = step && (cnt_q == osr_m1);
    assign emit = evt && (fills_q >= need);

    // Count accepted bits within one decimation period
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (evt) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Count decimation points since restart, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fills_q <= '0;
        end else if (evt && fills_q != 2'd3) begin
            fills_q <= fills_q + 1'b1;
        end
    end

    // R4: a restart leaves the bit counter at zero
    p_sync_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && fills_q == '0));

endmodule

// File: rtl/sinc_comb.sv
// Comb chain. Runs at the decimated rate. It picks the integrator output that
// matches the filter order and subtracts the delayed samples. The fast variant
// uses a delay of two decimated samples in its second comb. Assumes evt
// marks the decimation point and the integrator sums given are the updated ones.
module sinc_comb
    import sinc_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             evt,
    input  ftype_e           ftype,
    input  logic [ACC_W-1:0] i1,
    input  logic [ACC_W-1:0] i2,
    input  logic [ACC_W-1:0] i3,
    output logic [ACC_W-1:0] result
);

    logic [ACC_W-1:0] sel, c1, c2, c3, d2;
    logic [ACC_W-1:0] z1_q, z2_q, z2b_q, z3_q;

    // Pick the integrator stage that matches the filter order
    always_comb begin
        unique case (ftype)
            FT_SINC1:         sel = i1;
            FT_SINC2, FT_FAST: sel = i2;
            default:          sel = i3;
        endcase
    end

    assign d2 = (ftype == FT_FAST) ? z2b_q : z2_q;
    assign c1 = sel - z1_q;
    assign c2 = c1 - d2;
    assign c3 = c2 - z3_q;

    // Pick the comb output that matches the filter order
    always_comb begin
        unique case (ftype)
            FT_SINC1:         result = c1;
            FT_SINC2, FT_FAST: result = c2;
            default:          result = c3;
        endcase
    end

    // Shift the comb delay lines at each decimation point
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            z1_q  <= '0;
            z2_q  <= '0;
            z2b_q <= '0;
            z3_q  <= '0;
        end else if (evt) begin
            z1_q  <= sel;
            z2_q  <= c1;
            z2b_q <= z2_q;
            z3_q  <= c2;
        end
    end

    // R9: comb state moves only at decimation points
    p_comb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clear) |=> ($stable(z1_q) && $stable(z3_q)));

endmodule

// File: rtl/sinc_scale.sv
// Output formatting. Wide mode sign-extends the full result to 32 bits.
// Narrow mode shifts the result right arithmetically, saturates it to a signed
// 16-bit value and sign-extends that. Assumes ACC_W is at most 32.
module sinc_scale #(
    parameter int ACC_W = 26,
    parameter int OUT_W = 32,
    parameter int SH_W  = 5
) (
    input  logic [ACC_W-1:0] res,
    input  logic             wide,
    input  logic [SH_W-1:0]  shift,
    output logic [OUT_W-1:0] dout
);

    localparam int NARROW_W = 16;

    logic signed [ACC_W-1:0]    shifted;
    logic signed [NARROW_W-1:0] narrow;

    assign shifted = $signed(res) >>> shift;

    // Saturate the shifted value to the narrow range
    always_comb begin
        if (shifted > $signed(ACC_W'(32767))) begin
            narrow = 16'sh7fff;
        end else if (shifted < -$signed(ACC_W'(32768))) begin
            narrow = -16'sh8000;
        end else begin
            narrow = shifted[NARROW_W-1:0];
        end
    end

    // Pick wide or narrow output format
    assign dout = wide ? OUT_W'($signed(res)) : OUT_W'(narrow);

endmodule

// File: rtl/sinc_decim_chan.sv
// One sinc decimation channel. Ties together the integrators, the decimation
// control, the combs and the output scaling, and registers the output sample
// and its ready pulse. Assumes ftype and osr_m1 change only together with a
// restart (sync, or en low).
module sinc_decim_chan
    import sinc_pkg::*;
#(
    parameter int ACC_W = 26,
    parameter int CNT_W = 8,
    parameter int SH_W  = 5,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [1:0]       ftype,
    input  logic [CNT_W-1:0] osr_m1,
    input  logic             wide,
    input  logic [SH_W-1:0]  shift,
    output logic [OUT_W-1:0] data_out,
    output logic             data_rdy
);

    localparam int STAGES = 3;

    logic                          clear, step, evt, emit;
    logic [STAGES-1:0][ACC_W-1:0]  acc_nxt;
    logic [ACC_W-1:0]              result;
    logic [OUT_W-1:0]              scaled;
    ftype_e                        ft;

    assign ft    = ftype_e'(ftype);
    assign clear = sync || !en;
    assign step  = bit_valid && !clear;

    sinc_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (step),
        .bit_in  (bit_in),
        .acc_nxt (acc_nxt)
    );

    sinc_decim_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step),
        .osr_m1 (osr_m1),
        .ftype  (ft),
        .evt    (evt),
        .emit   (emit)
    );

    sinc_comb #(.ACC_W(ACC_W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .evt    (evt),
        .ftype  (ft),
        .i1     (acc_nxt[0]),
        .i2     (acc_nxt[1]),
        .i3     (acc_nxt[2]),
        .result (result)
    );

    sinc_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
        .res   (result),
        .wide  (wide),
        .shift (shift),
        .dout  (scaled)
    );

    // Register the sample and its ready pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_rdy <= 1'b0;
        end else begin
            data_rdy <= emit;
            if (emit) begin
                data_out <= scaled;
            end
        end
    end

    // R2: a ready pulse follows an accepted bit
    p_rdy_after_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |-> $past(bit_valid && en && !sync));

    // R5: no ready pulse while the channel is disabled
    p_no_rdy_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !data_rdy);

    // R8: output holds between ready pulses
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rdy |-> $stable(data_out));

endmodule

// File: tb/test_sinc_decim_chan.sv
`timescale 1ns/1ps
module test_sinc_decim_chan;

    logic        clk = 1'b0;
    logic        rst_n, en, sync, bit_valid, bit_in, wide;
    logic [1:0]  ftype;
    logic [7:0]  osr_m1;
    logic [4:0]  shift;
    logic [31:0] data_out;
    logic        data_rdy;

    always #2.5 clk = ~clk;

    sinc_decim_chan i_sinc_decim_chan (
        .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
        .bit_valid(bit_valid), .bit_in(bit_in), .ftype(ftype),
        .osr_m1(osr_m1), .wide(wide), .shift(shift),
        .data_out(data_out), .data_rdy(data_rdy)
    );

    int n_vec = 0;
    int n_bad = 0;
    int hist [0:1023];
    int hk   [0:1023];
    int htmp [0:1023];
    int hlen, wp, cnt, evts, ratio, ty, need_k;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input longint act, input longint exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 1024; i++) hist[i] = 0;
        wp = 0; cnt = 0; evts = 0;
    endtask

    // Build the impulse response by convolving boxes
    task automatic build_kernel();
        int boxes [3];
        int nbox;
        nbox = (ty == 0) ? 1 : (ty == 3) ? 3 : 2;
        boxes[0] = ratio;
        boxes[1] = (ty == 2) ? 2 * ratio : ratio;
        boxes[2] = ratio;
        for (int i = 0; i < 1024; i++) hk[i] = 0;
        hk[0] = 1; hlen = 1;
        for (int b = 0; b < nbox; b++) begin
            for (int k = 0; k < 1024; k++) begin
                htmp[k] = 0;
                for (int j = 0; j < boxes[b]; j++)
                    if (k - j >= 0) htmp[k] += hk[k - j];
            end
            hlen += boxes[b] - 1;
            for (int k = 0; k < 1024; k++) hk[k] = htmp[k];
        end
        need_k = (ty == 0) ? 1 : (ty == 1) ? 2 : 3;
    endtask

    function automatic longint expected_out();
        longint y = 0;
        longint t;
        for (int k = 0; k < hlen; k++)
            y += longint'(hk[k]) * hist[(wp - 1 - k) & 1023];
        if (wide) return y;
        t = y >>> shift;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    // Restart with the sync strobe; the bit shown with it must be dropped (R4)
    task automatic restart(input int t, input int r);
        ty = t; ratio = r;
        ftype = 2'(t); osr_m1 = 8'(r - 1);
        build_kernel();
        sync = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        sync = 1'b0; bit_valid = 1'b0;
        model_clear();
        chk("R4 rdy at sync", longint'(data_rdy), 0);
    endtask

    // Apply one bit at a negedge, sample at the next negedge
    task automatic push_bit(input logic b, input int gap);
        logic [31:0] held;
        held = data_out;
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
        if (!en) begin
            model_clear();
            chk("R5 rdy disabled", longint'(data_rdy), 0);
            chk("R8 hold disabled", longint'(data_out), longint'(held));
        end else begin
            hist[wp] = b ? 1 : -1;
            wp = (wp + 1) & 1023;
            cnt++;
            if (cnt == ratio) begin
                cnt = 0; evts++;
                if (evts >= need_k) begin
                    chk("R2 rdy at point", longint'(data_rdy), 1);
                    if (wide) chk("R1/R6 sample", longint'($signed(data_out)), expected_out());
                    else      chk("R7 narrow", longint'($signed(data_out)), expected_out());
                end else begin
                    chk("R3 suppressed", longint'(data_rdy), 0);
                end
            end else begin
                chk("R2 no rdy", longint'(data_rdy), 0);
            end
        end
        for (int g = 0; g < gap; g++) begin
            held = data_out;
            @(negedge clk);
            chk("R9 idle rdy", longint'(data_rdy), 0);
            chk("R8 idle hold", longint'(data_out), longint'(held));
        end
    endtask

    function automatic logic pat_bit(input int pat, input int i);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return i[0];
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                return lfsr[0];
            end
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int ratios [6] = '{1, 2, 3, 4, 7, 8};
        rst_n = 1'b0; en = 1'b1; sync = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        ftype = 2'd0; osr_m1 = 8'd0; wide = 1'b1; shift = 5'd0;
        repeat (3) @(negedge clk);
        chk("R8 reset rdy", longint'(data_rdy), 0);
        chk("R8 reset data", longint'(data_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of shapes, ratios and patterns at full precision (R1, R2, R3, R6, R9)
        for (int t = 0; t < 4; t++)
            for (int ri = 0; ri < 6; ri++)
                for (int p = 0; p < 4; p++) begin
                    restart(t, ratios[ri]);
                    for (int i = 0; i < 4 * ratios[ri] + 5; i++)
                        push_bit(pat_bit(p, i), (p == 3 && i % 3 == 0) ? 1 : 0);
                end

        // Full-scale third order at the largest ratio (R6)
        restart(3, 256);
        for (int i = 0; i < 3 * 256; i++) push_bit(1'b1, 0);
        restart(3, 256);
        for (int i = 0; i < 3 * 256; i++) push_bit(1'b0, 0);

        // Narrow mode: saturation and shift (R7)
        wide = 1'b0;
        for (int s = 0; s < 4; s++) begin
            shift = (s == 0) ? 5'd0 : (s == 1) ? 5'd4 : (s == 2) ? 5'd10 : 5'd31;
            for (int p = 0; p < 4; p++) begin
                restart(3, 64);
                for (int i = 0; i < 4 * 64; i++) push_bit(pat_bit(p, i), 0);
            end
        end
        wide = 1'b1; shift = 5'd0;

        // Restart in mid-stream (R3, R4)
        restart(1, 5);
        for (int i = 0; i < 7; i++) push_bit(pat_bit(3, i), 0);
        restart(1, 5);
        for (int i = 0; i < 17; i++) push_bit(pat_bit(2, i), 0);
        restart(2, 3);
        for (int i = 0; i < 4; i++) push_bit(1'b1, 0);
        restart(2, 3);
        for (int i = 0; i < 12; i++) push_bit(1'b0, 0);

        // Disable and re-enable (R5, R8)
        restart(0, 4);
        for (int i = 0; i < 6; i++) push_bit(1'b1, 0);
        en = 1'b0;
        for (int i = 0; i < 5; i++) push_bit(1'b0, 0);
        en = 1'b1;
        for (int i = 0; i < 10; i++) push_bit(pat_bit(3, i), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule